// File: doc/BRIEF.md
# Vector Widening Multiply-Accumulate Unit

This block is the arithmetic core of a vector multiply-accumulate operation that widens its result. Each cycle it can accept one packed group of source elements from each of two operands, along with the previous destination group at twice the element width. For every active element it forms the double-width product of the two source elements and adds it to the matching destination element. The updated destination group comes out with a valid flag two cycles later.

The element width is chosen per operation as 8, 16 or 32 bits. Elements are always packed into a 128-bit source group and a 256-bit destination group. A mode input selects between two's-complement and unsigned interpretation of both multiplier inputs. A per-element mask, together with a mask-enable flag, decides which destination elements are rewritten. Masked-off elements keep their old value. Register-file access, instruction decode, group-size legality and tail handling all belong to the surrounding pipeline.

Top module: `wmac_unit`

## Requirements
- R1: For every updated element i, the result element equals the old destination element plus the product of source element i of src_a and source element i of src_b, with the product formed at 2*SEW bits.
- R2: With is_signed = 1, both multiplier inputs are read as two's-complement signed integers.
- R3: With is_signed = 0, both multiplier inputs are read as unsigned integers.
- R4: sew_sel encodes the element width as 0 = 8 bits, 1 = 16 bits and 2 = 32 bits; encoding 3 behaves as 32 bits. Source element i occupies bits [i*SEW +: SEW] and destination element i occupies bits [i*2*SEW +: 2*SEW].
- R5: With mask_en = 1, element i is updated only when elem_mask[i] = 1. Otherwise the old destination element appears unchanged in the result.
- R6: With mask_en = 0, every element is updated whatever elem_mask holds.
- R7: elem_mask bits at an index at or above the element count for the chosen width (16, 8 or 4) have no effect on the result.
- R8: Each element sum wraps modulo 2^(2*SEW), and no carry crosses into a neighbouring element.
- R9: out_valid rises exactly two clock cycles after the cycle in which in_valid is sampled high, with the matching result. Inputs may be applied on consecutive cycles, and each yields its own output.
- R10: A synchronous active-high rst clears the pipeline, so out_valid is 0 after reset. An operation accepted just before reset never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| src_a | input | 128 | Packed first multiplier source group |
| src_b | input | 128 | Packed second multiplier source group |
| acc_in | input | 256 | Old destination group, double-width elements |
| elem_mask | input | 16 | Per-element update mask, bit i for element i |
| mask_en | input | 1 | 1 = apply elem_mask, 0 = update all elements |
| is_signed | input | 1 | 1 = signed multiply, 0 = unsigned |
| sew_sel | input | 2 | Element width select |
| out_valid | output | 1 | Result group valid |
| result | output | 256 | Updated destination group |

## Verification
The hardest case to reach from the ports is the interaction between element width and masking. The same mask bit selects a byte pair at 8 bits and a 64-bit lane at 32 bits, and the upper mask bits must become inert at wider widths. The stimulus sends one group at 32-bit width with only the upper twelve mask bits set and expects the old destination back unchanged. It also sends alternating mask patterns at 8-bit width. A second case is the per-element wrap. An all-ones accumulator plus a product of one must give zero in every lane without carrying into the next lane, which exposes any adder that spans lane boundaries.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

    typedef enum logic [1:0] {
        SEW_8   = 2'd0,
        SEW_16  = 2'd1,
        SEW_32  = 2'd2,
        SEW_32R = 2'd3
    } sew_e;

    localparam int NUM_WIDTHS = 3;

    function automatic int width_index(input sew_e s);
        case (s)
            SEW_8:   return 0;
            SEW_16:  return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/wmac_mul_lanes.sv
module wmac_mul_lanes #(
    parameter int SRC_W = 128,
    parameter int EW    = 8
) (
    input  logic [SRC_W-1:0]   a,
    input  logic [SRC_W-1:0]   b,
    input  logic               is_signed,
    output logic [2*SRC_W-1:0] prod
);
    localparam int LANES = SRC_W / EW;
    localparam int PW    = 2 * EW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [EW-1:0] a_el;
        logic [EW-1:0] b_el;
        logic [PW-1:0] a_ext;
        logic [PW-1:0] b_ext;
        logic [PW-1:0] p;

        always_comb begin
            a_el  = a[i*EW +: EW];
            b_el  = b[i*EW +: EW];
            a_ext = {{EW{is_signed & a_el[EW-1]}}, a_el};
            b_ext = {{EW{is_signed & b_el[EW-1]}}, b_el};
            p     = a_ext * b_ext;
        end

        assign prod[i*PW +: PW] = p;
    end

endmodule

// File: rtl/wmac_acc_lanes.sv
module wmac_acc_lanes #(
    parameter int ACC_W = 256,
    parameter int EW    = 8
) (
    input  logic [ACC_W-1:0]            prod,
    input  logic [ACC_W-1:0]            acc,
    input  logic [ACC_W/(2*EW)-1:0]     upd,
    output logic [ACC_W-1:0]            res
);
    localparam int PW    = 2 * EW;
    localparam int LANES = ACC_W / PW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PW-1:0] sum;

        always_comb begin
            sum = acc[i*PW +: PW] + prod[i*PW +: PW];
        end

        assign res[i*PW +: PW] = upd[i] ? sum : acc[i*PW +: PW];
    end

endmodule

// File: rtl/wmac_unit.sv
module wmac_unit #(
    parameter int SRC_W = 128
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [SRC_W-1:0]     src_a,
    input  logic [SRC_W-1:0]     src_b,
    input  logic [2*SRC_W-1:0]   acc_in,
    input  logic [SRC_W/8-1:0]   elem_mask,
    input  logic                 mask_en,
    input  logic                 is_signed,
    input  logic [1:0]           sew_sel,
    output logic                 out_valid,
    output logic [2*SRC_W-1:0]   result
);
    import wmac_pkg::*;

    localparam int ACC_W  = 2 * SRC_W;
    localparam int MASK_W = SRC_W / 8;

    typedef struct packed {
        logic              s1_vld;
        logic [ACC_W-1:0]  s1_prod;
        logic [ACC_W-1:0]  s1_acc;
        logic [MASK_W-1:0] s1_upd;
        sew_e              s1_sew;
        logic              s2_vld;
        logic [ACC_W-1:0]  s2_res;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [ACC_W-1:0] prod_v [NUM_WIDTHS];
    logic [ACC_W-1:0] res_v  [NUM_WIDTHS];
    sew_e             sew_in;

    assign sew_in = sew_e'(sew_sel);

    for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
        localparam int EW = 8 << w;

        wmac_mul_lanes #(
            .SRC_W (SRC_W),
            .EW    (EW)
        ) mul_i (
            .a         (src_a),
            .b         (src_b),
            .is_signed (is_signed),
            .prod      (prod_v[w])
        );

        wmac_acc_lanes #(
            .ACC_W (ACC_W),
            .EW    (EW)
        ) acc_i (
            .prod (pipe_q.s1_prod),
            .acc  (pipe_q.s1_acc),
            .upd  (pipe_q.s1_upd[ACC_W/(2*EW)-1:0]),
            .res  (res_v[w])
        );
    end

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: multiply and capture operands.
        pipe_d.s1_vld = in_valid;
        if (in_valid) begin
            pipe_d.s1_prod = prod_v[width_index(sew_in)];
            pipe_d.s1_acc  = acc_in;
            pipe_d.s1_upd  = elem_mask | {MASK_W{~mask_en}};
            pipe_d.s1_sew  = sew_in;
        end

        // Stage 2: accumulate and merge masked lanes.
        pipe_d.s2_vld = pipe_q.s1_vld;
        if (pipe_q.s1_vld) begin
            pipe_d.s2_res = res_v[width_index(pipe_q.s1_sew)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s2_vld;
    assign result    = pipe_q.s2_res;

endmodule

// File: rtl/wmac_unit_chk.sv
module wmac_unit_chk #(
    parameter int SRC_W = 128
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [SRC_W-1:0]     src_a,
    input logic [SRC_W-1:0]     src_b,
    input logic [2*SRC_W-1:0]   acc_in,
    input logic [SRC_W/8-1:0]   elem_mask,
    input logic                 mask_en,
    input logic                 is_signed,
    input logic [1:0]           sew_sel,
    input logic                 out_valid,
    input logic [2*SRC_W-1:0]   result
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 2'd1;
        end
    end

    // R9: fixed two-cycle latency of the valid flag.
    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R10: nothing emerges in the first cycle after reset.
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd0) |-> !out_valid);

    // R5: every lane masked off returns the old destination.
    assert_mask_pass_R5: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd2) && out_valid &&
         $past(mask_en && (elem_mask == '0), 2)) |->
        (result == $past(acc_in, 2)));

    // R3: 32-bit unsigned element 0.
    assert_u32_lane0_R3: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd2) && out_valid &&
         $past(!is_signed && (sew_sel == 2'd2) && (!mask_en || elem_mask[0]), 2)) |->
        (result[63:0] == $past(acc_in[63:0] +
                               ({32'd0, src_a[31:0]} * {32'd0, src_b[31:0]}), 2)));

    // R2: 8-bit signed element 0.
    assert_s8_lane0_R2: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd2) && out_valid &&
         $past(is_signed && (sew_sel == 2'd0) && (!mask_en || elem_mask[0]), 2)) |->
        (result[15:0] == $past(acc_in[15:0] +
                               ({{8{src_a[7]}}, src_a[7:0]} * {{8{src_b[7]}}, src_b[7:0]}), 2)));

endmodule

bind wmac_unit wmac_unit_chk #(.SRC_W(SRC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .acc_in    (acc_in),
    .elem_mask (elem_mask),
    .mask_en   (mask_en),
    .is_signed (is_signed),
    .sew_sel   (sew_sel),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/wmac_unit_tb_top.sv
module wmac_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic [255:0] acc_in;
    logic [15:0]  elem_mask;
    logic         mask_en;
    logic         is_signed;
    logic [1:0]   sew_sel;
    logic         out_valid;
    logic [255:0] result;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    wmac_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .acc_in    (acc_in),
        .elem_mask (elem_mask),
        .mask_en   (mask_en),
        .is_signed (is_signed),
        .sew_sel   (sew_sel),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] rnd32();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [127:0] rnd128();
        return {rnd32(), rnd32(), rnd32(), rnd32()};
    endfunction

    // Independent model of the requirements R1-style arithmetic per element.
    function automatic logic [255:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [255:0] acc, input logic [15:0] m,
                                           input logic men, input logic sg, input logic [1:0] sw);
        int ew = (sw == 2'd0) ? 8 : (sw == 2'd1) ? 16 : 32;
        int n  = 128 / ew;
        logic [255:0] r = acc;
        logic [63:0] emask = (ew == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2*ew)) - 64'd1);
        logic [63:0] smask = (64'd1 << ew) - 64'd1;
        for (int i = 0; i < n; i++) begin
            logic [63:0] ua = 64'(a >> (i*ew)) & smask;
            logic [63:0] ub = 64'(b >> (i*ew)) & smask;
            logic [63:0] ac = 64'(acc >> (i*2*ew)) & emask;
            longint ea = longint'(ua);
            longint eb = longint'(ub);
            logic [63:0] s;
            if (sg && ua[ew-1]) ea = ea - (longint'(1) << ew);
            if (sg && ub[ew-1]) eb = eb - (longint'(1) << ew);
            s = (ac + 64'(ea * eb)) & emask;
            if (!men || m[i]) begin
                r = (r & ~({192'd0, emask} << (i*2*ew))) | ({192'd0, s} << (i*2*ew));
            end
        end
        return r;
    endfunction

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: out_valid=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_res(input string req, input logic [255:0] exp);
        n_vec++;
        if (out_valid !== 1'b1 || result !== exp) begin
            n_bad++;
            $display("FAIL %s: valid=%0b result=%h expected=%h", req, out_valid, result, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [127:0] a, input logic [127:0] b,
                         input logic [255:0] acc, input logic [15:0] m,
                         input logic men, input logic sg, input logic [1:0] sw);
        in_valid = v; src_a = a; src_b = b; acc_in = acc;
        elem_mask = m; mask_en = men; is_signed = sg; sew_sel = sw;
    endtask

    // One operation through an empty pipeline; result checked two cycles later.
    task automatic run_one(input string req, input logic [127:0] a, input logic [127:0] b,
                           input logic [255:0] acc, input logic [15:0] m,
                           input logic men, input logic sg, input logic [1:0] sw);
        @(negedge clk);
        drive(1'b1, a, b, acc, m, men, sg, sw);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk_res(req, model(a, b, acc, m, men, sg, sw));
    endtask

    task automatic t_reset();
        // R10: pipeline empty after reset
        chk_bit("R10 reset state", out_valid, 1'b0);
    endtask

    task automatic t_signed8();
        // R2, R4: 8-bit signed, including -128*-128 and -128*127
        run_one("R2 sew8 signed random", rnd128(), rnd128(), {rnd128(), rnd128()}, 16'h0, 1'b0, 1'b1, 2'd0);
        run_one("R2 sew8 signed extremes", {16{8'h80}}, {8{8'h80, 8'h7F}}, 256'd0, 16'h0, 1'b0, 1'b1, 2'd0);
        @(negedge clk);
        drive(1'b1, {16{8'hFF}}, {16{8'h02}}, 256'd0, 16'h0, 1'b0, 1'b1, 2'd0);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk_res("R2 sew8 signed -1*2 = FFFE", {16{16'hFFFE}});
    endtask

    task automatic t_unsigned16();
        // R3, R4: 16-bit unsigned, FFFF*FFFF
        run_one("R3 sew16 unsigned random", rnd128(), rnd128(), {rnd128(), rnd128()}, 16'h0, 1'b0, 1'b0, 2'd1);
        @(negedge clk);
        drive(1'b1, {8{16'hFFFF}}, {8{16'hFFFF}}, 256'd0, 16'h0, 1'b0, 1'b0, 2'd1);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk_res("R3 sew16 unsigned FFFF*FFFF", {8{32'hFFFE_0001}});
        run_one("R2 sew16 signed random", rnd128(), rnd128(), {rnd128(), rnd128()}, 16'h0, 1'b0, 1'b1, 2'd1);
    endtask

    task automatic t_wide32();
        // R1, R4: 32-bit both modes and the encoding 3
        run_one("R1 sew32 unsigned random", rnd128(), rnd128(), {rnd128(), rnd128()}, 16'h0, 1'b0, 1'b0, 2'd2);
        run_one("R2 sew32 signed random", rnd128(), rnd128(), {rnd128(), rnd128()}, 16'h0, 1'b0, 1'b1, 2'd2);
        run_one("R4 sew encoding 3 acts as 32", rnd128(), rnd128(), {rnd128(), rnd128()}, 16'h0, 1'b0, 1'b1, 2'd3);
    endtask

    task automatic t_wrap();
        // R8: all-ones accumulator plus 1*1 wraps to zero per lane, no carry out
        @(negedge clk);
        drive(1'b1, {16{8'h01}}, {16{8'h01}}, {256{1'b1}}, 16'h0, 1'b0, 1'b0, 2'd0);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk_res("R8 per-lane wrap", 256'd0);
        run_one("R8 sew32 signed wrap", {4{32'h8000_0000}}, {4{32'h8000_0000}},
                {4{64'hC000_0000_0000_0000}}, 16'h0, 1'b0, 1'b1, 2'd2);
    endtask

    task automatic t_mask();
        logic [255:0] acc = {rnd128(), rnd128()};
        // R5: alternating mask at 8 bits
        run_one("R5 sew8 mask 5A5A", rnd128(), rnd128(), acc, 16'h5A5A, 1'b1, 1'b1, 2'd0);
        // R5: all masked off returns acc exactly
        @(negedge clk);
        drive(1'b1, rnd128(), rnd128(), acc, 16'h0000, 1'b1, 1'b0, 2'd1);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk_res("R5 all lanes masked off", acc);
        // R7: only mask bits above the 4 lanes of 32-bit are set
        @(negedge clk);
        drive(1'b1, {4{32'h0000_0003}}, {4{32'h0000_0005}}, acc, 16'hFFF0, 1'b1, 1'b0, 2'd2);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk_res("R7 high mask bits inert", acc);
        // R6: mask disabled, mask zero, all lanes updated
        @(negedge clk);
        drive(1'b1, {4{32'h0000_0003}}, {4{32'h0000_0005}}, 256'd0, 16'h0000, 1'b0, 1'b0, 2'd2);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk_res("R6 mask disabled updates all", {4{64'd15}});
    endtask

    task automatic t_latency();
        // R9: valid low after one cycle, high after two, low after three
        @(negedge clk);
        drive(1'b1, rnd128(), rnd128(), 256'd0, 16'h0, 1'b0, 1'b0, 2'd0);
        @(negedge clk); in_valid = 1'b0;
        chk_bit("R9 no output after one cycle", out_valid, 1'b0);
        @(negedge clk);
        chk_bit("R9 output after two cycles", out_valid, 1'b1);
        @(negedge clk);
        chk_bit("R9 single pulse", out_valid, 1'b0);
    endtask

    task automatic t_stream();
        // R9, R1: back-to-back operations with mixed widths and modes
        localparam int NS = 6;
        logic [255:0] exp_q [NS];
        for (int k = 0; k < NS + 2; k++) begin
            @(negedge clk);
            if (k >= 2) chk_res("R9 back-to-back stream", exp_q[k-2]);
            if (k < NS) begin
                logic [127:0] a = rnd128();
                logic [127:0] b = rnd128();
                logic [255:0] acc = {rnd128(), rnd128()};
                logic [15:0]  m = rnd32()[15:0];
                logic [1:0]   sw = 2'(k % 3);
                logic         sg = k[0];
                logic         men = k[1];
                drive(1'b1, a, b, acc, m, men, sg, sw);
                exp_q[k] = model(a, b, acc, m, men, sg, sw);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_reset_mid();
        // R10: an operation in flight is dropped by reset
        @(negedge clk);
        drive(1'b1, rnd128(), rnd128(), 256'd0, 16'h0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk_bit("R10 flush during reset", out_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_bit("R10 no output after reset", out_valid, 1'b0);
    endtask

    bit done = 1'b0;

    initial begin
        rst = 1'b1;
        drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 2'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_signed8();
        t_unsigned16();
        t_wide32();
        t_wrap();
        t_mask();
        t_latency();
        t_stream();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule